// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Sequencer

This block is the digital control side of a slow delta-sigma converter. It runs a repeating cycle of three phases. First it converts for a fixed number of system clocks, chosen by a rate-select input that stands for the two line-rejection settings. Then it sleeps, holding a result latched from a stub conversion source. Then it outputs that result on a single serial data pin, clocked by an external host.

A single pin carries both the status and the data. When chip select is high the pin is released. When chip select is low during conversion or sleep, the pin shows a busy flag: 1 while converting, 0 once the result is ready. The flag drops in the same cycle that the conversion completes.

When chip select is low in sleep, the block enters the output phase and shifts out a 24-bit word, most significant bit first. The word holds the busy flag, a dummy bit, a sign bit with overrange coding, and the result. The host's serial clock is brought into the system clock domain by a synchronizer, and only its edges are used.

Top module: `adc_seq_top`

## Requirements
- R1: While `cs_n_i` is high, `sdo_oe_o` is 0 (pin released); while it is low, `sdo_oe_o` is 1.
- R2: With `cs_n_i` low during conversion, `sdo_o` reads 1; during sleep it reads 0.
- R3: After reset the conversion lasts exactly `CYC_A` clocks when `rate_sel_i`=0 and `CYC_B` clocks when it is 1. `sdo_o` falls to 0 in the cycle the conversion ends.
- R4: The output word is MSB first. Bit 23 is 0 (ready flag) and bit 22 is a dummy 0. For an in-range result r, bit 21 = NOT r[19], bit 20 = r[19], and bits 19..0 = r[19:0].
- R5: When `over_i` is set at the end of conversion, bits 21..0 are 2'b11 followed by all zeros. When only `under_i` is set, they are 2'b00 followed by all ones. `over_i` wins if both are set.
- R6: Output starts only from sleep with `cs_n_i` low. Bit 23 is on `sdo_o` before the first rising serial clock edge, each later bit appears on a falling edge, and `sdo_o` does not change on a rising edge. Serial clock edges during conversion have no effect.
- R7: After the 24th rising serial clock edge the block returns to conversion, and `sdo_o` reads 1 with `cs_n_i` low.
- R8: Raising `cs_n_i` before the 24th rising edge ends the output and starts a new conversion, which latches fresh source data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 1 | Conversion length select (0: CYC_A, 1: CYC_B) |
| res_i | input | RES_W | Signed result from the stub source |
| over_i | input | 1 | Source flags input above positive full scale |
| under_i | input | 1 | Source flags input below negative full scale |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Host-driven serial clock (asynchronous) |
| sdo_o | output | 1 | Serial status/data value |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
The checker tests the phase transitions on every cycle. These are: entry to output only from sleep with chip select low, return to conversion after the last rising edge or on an abort, conversion completion going straight to sleep, and the data bit holding still unless a falling edge was seen. Some behaviour can only be shown by the bench scenarios, because it depends on values the checker does not model. These are the exact conversion lengths for both rate settings, the bit-by-bit content of the word for positive, negative, overrange and underrange results, and the fact that an aborted read starts a conversion that captures new data.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OUT   = 2'd2
    } seq_state_e;

    // Word layout: ready flag, dummy, sign, sign-extended result.
    function automatic logic [23:0] build_word(input logic [19:0] res,
                                               input logic        over,
                                               input logic        under);
        logic [21:0] field;
        if (over)
            field = {2'b11, 20'h00000};
        else if (under)
            field = {2'b00, 20'hFFFFF};
        else
            field = {~res[19], res[19], res};
        return {1'b0, 1'b0, field};
    endfunction

endpackage

// File: rtl/adc_seq_edge_det.sv
module adc_seq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], sclk_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    assign fall_o = ~chain_q[CHAIN_W-2] & chain_q[CHAIN_W-1];
endmodule

// File: rtl/adc_seq_conv_timer.sv
module adc_seq_conv_timer #(
    parameter int CYC_A = 133,
    parameter int CYC_B = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sel_i,
    output logic done_o
);
    localparam int MAX_CYC = (CYC_A > CYC_B) ? CYC_A : CYC_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(CYC_A - 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(CYC_B - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = sel_i ? LAST_B : LAST_A;
        done_o = run_i && (cnt_q == last);
        if (!run_i || done_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = word_i;
        else if (shift_i) sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 20,
    parameter int CYC_A       = 133,
    parameter int CYC_B       = 160,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             over_i,
    input  logic             under_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);
    localparam int WORD_W = RES_W + 4;
    localparam int BCNT_W = $clog2(WORD_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [BCNT_W-1:0] bcnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic sclk_rise, sclk_fall;
    logic conv_done;
    logic sh_load, sh_shift, sh_bit;
    logic [WORD_W-1:0] word;

    adc_seq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    adc_seq_conv_timer #(.CYC_A(CYC_A), .CYC_B(CYC_B)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.state == ST_CONV),
        .sel_i  (rate_sel_i),
        .done_o (conv_done)
    );

    assign word     = build_word(res_i, over_i, under_i);
    assign sh_load  = conv_done;
    assign sh_shift = (r_q.state == ST_OUT) && !cs_n_i && sclk_fall
                      && (r_q.bcnt != '0);

    adc_seq_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .word_i  (word),
        .shift_i (sh_shift),
        .bit_o   (sh_bit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_CONV: begin
                r_d.bcnt = '0;
                if (conv_done) r_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                r_d.bcnt = '0;
                if (!cs_n_i) r_d.state = ST_OUT;
            end
            ST_OUT: begin
                if (cs_n_i) begin
                    r_d.state = ST_CONV;
                    r_d.bcnt  = '0;
                end else if (sclk_rise) begin
                    if (r_q.bcnt == LAST_BIT) begin
                        r_d.state = ST_CONV;
                        r_d.bcnt  = '0;
                    end else begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end
            default: begin
                r_d.state = ST_CONV;
                r_d.bcnt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_CONV;
            r_q.bcnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_CONV:  sdo_o = 1'b1;
            ST_SLEEP: sdo_o = 1'b0;
            default:  sdo_o = sh_bit;
        endcase
    end

    assign sdo_oe_o = !cs_n_i;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int BCNT_W = 5,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input seq_state_e        state,
    input logic              rise,
    input logic              fall,
    input logic [BCNT_W-1:0] bit_cnt,
    input logic              sdo,
    input logic              conv_done
);
    // R6: sleep with select low leads into output
    a_r6_enter_out: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !cs_n) |=> (state == ST_OUT));

    // R6: output phase is reached only from sleep
    a_r6_only_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_OUT) |-> $past(state == ST_SLEEP));

    // R6: data bit moves only after a falling edge
    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && $past(state == ST_OUT) && !$past(fall)) |-> $stable(sdo));

    // R7: last rising edge returns to conversion
    a_r7_end_of_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && !cs_n && rise && bit_cnt == BCNT_W'(WORD_W - 1))
        |=> (state == ST_CONV));

    // R8: deselect during output aborts to conversion
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && cs_n) |=> (state == ST_CONV));

    // R3: end of conversion moves to sleep
    a_r3_done_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (state == ST_SLEEP));

    // R6: bit counter never passes the word length
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT) |-> (bit_cnt < BCNT_W'(WORD_W)));
endmodule

bind adc_seq_top adc_seq_chk #(.BCNT_W(BCNT_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n_i),
    .state     (r_q.state),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .bit_cnt   (r_q.bcnt),
    .sdo       (sdo_o),
    .conv_done (conv_done)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_A = 133;
    localparam int CYC_B = 160;
    localparam int HOLD  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_sel_i = 1'b0;
    logic [19:0] res_i = '0;
    logic        over_i = 1'b0;
    logic        under_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        sclk_i = 1'b0;
    logic        sdo_o, sdo_oe_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_top #(.RES_W(20), .CYC_A(CYC_A), .CYC_B(CYC_B)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel_i),
        .res_i      (res_i),
        .over_i     (over_i),
        .under_i    (under_i),
        .cs_n_i     (cs_n_i),
        .sclk_i     (sclk_i),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(input logic [19:0] r, input logic ov,
                                             input logic un);
        if (ov)      return {2'b00, 2'b11, 20'h00000};
        else if (un) return {2'b00, 2'b00, 20'hFFFFF};
        else         return {2'b00, ~r[19], r[19], r};
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n_i = 1'b1; sclk_i = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
    endtask

    // Counts clocks from conversion start until the flag drops.
    task automatic measure_conv(input logic sel, input int exp, input string req);
        int n;
        rate_sel_i = sel;
        apply_reset();
        cs_n_i = 1'b0;
        #1;
        check(sdo_o === 1'b1 && sdo_oe_o === 1'b1, "R2 busy flag", sdo_o, 1);
        n = 0;
        while (sdo_o === 1'b1 && n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
        end
        check(n == exp, req, n, exp);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (sdo_o !== 1'b0 && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    // Reads a full word; assumes cs_n low and sleep/output reached.
    task automatic read_word(output logic [23:0] w);
        bit rise_moved = 0;
        w[23] = sdo_o;
        for (int k = 1; k < 24; k++) begin
            sclk_i = 1'b1; wait_clks(HOLD);
            if (sdo_o !== w[24-k]) rise_moved = 1;
            sclk_i = 1'b0; wait_clks(HOLD);
            w[23-k] = sdo_o;
        end
        sclk_i = 1'b1; wait_clks(HOLD);
        check(!rise_moved, "R6 no change on rising edge", rise_moved, 0);
        check(sdo_o === 1'b1 && sdo_oe_o === 1'b1, "R7 back to converting", sdo_o, 1);
        sclk_i = 1'b0; wait_clks(HOLD);
    endtask

    task automatic t_reset_and_select();
        apply_reset();
        #1;
        check(sdo_oe_o === 1'b0, "R1 released when deselected", sdo_oe_o, 0);
        cs_n_i = 1'b0; #1;
        check(sdo_oe_o === 1'b1, "R1 driven when selected", sdo_oe_o, 1);
        cs_n_i = 1'b1;
    endtask

    task automatic t_positive();
        logic [23:0] w;
        res_i = 20'h12345; over_i = 0; under_i = 0;
        measure_conv(1'b0, CYC_A, "R3 length rate 0");
        check(sdo_o === 1'b0, "R2 ready flag in sleep", sdo_o, 0);
        read_word(w);
        check(w == exp_word(20'h12345, 0, 0), "R4 positive word", w, exp_word(20'h12345, 0, 0));
    endtask

    task automatic t_negative();
        logic [23:0] w;
        res_i = 20'hFFFFB; over_i = 0; under_i = 0;
        measure_conv(1'b1, CYC_B, "R3 length rate 1");
        read_word(w);
        check(w == exp_word(20'hFFFFB, 0, 0), "R4 negative word", w, exp_word(20'hFFFFB, 0, 0));
    endtask

    task automatic t_range();
        logic [23:0] w;
        rate_sel_i = 1'b0;
        res_i = 20'h00042; over_i = 1; under_i = 1;
        wait_ready();
        read_word(w);
        check(w == exp_word(0, 1, 0), "R5 over range word", w, exp_word(0, 1, 0));
        over_i = 0; under_i = 1;
        wait_ready();
        read_word(w);
        check(w == exp_word(0, 0, 1), "R5 under range word", w, exp_word(0, 0, 1));
        under_i = 0;
    endtask

    task automatic t_abort_and_ignore();
        logic [23:0] w;
        res_i = 20'h0ABCD;
        wait_ready();
        for (int k = 0; k < 5; k++) begin
            sclk_i = 1'b1; wait_clks(HOLD);
            sclk_i = 1'b0; wait_clks(HOLD);
        end
        cs_n_i = 1'b1; res_i = 20'h00777;
        wait_clks(2);
        check(sdo_oe_o === 1'b0, "R8 released after abort", sdo_oe_o, 0);
        cs_n_i = 1'b0; #1;
        check(sdo_o === 1'b1, "R8 new conversion after abort", sdo_o, 1);
        for (int k = 0; k < 3; k++) begin
            sclk_i = 1'b1; wait_clks(HOLD);
            sclk_i = 1'b0; wait_clks(HOLD);
        end
        check(sdo_o === 1'b1, "R6 edges ignored in conversion", sdo_o, 1);
        wait_ready();
        read_word(w);
        check(w == exp_word(20'h00777, 0, 0), "R8 fresh data after abort", w,
              exp_word(20'h00777, 0, 0));
    endtask

    initial begin
        t_reset_and_select();
        t_positive();
        t_negative();
        t_range();
        t_abort_and_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule